// File: doc/BRIEF.md
# Three-Leg Half-Bridge Gate Controller

This block sits between a serial command interface and the gate drivers of three half-bridges. Each half-bridge has a low-side and a high-side switch. The block keeps the last command word loaded by the interface. From that word, an external PWM pin and a set of per-switch fault comparators, it computes six gate enables. It also keeps a status word that the interface shifts back to the host. The status word carries latched fault flags and a live thermal prewarning.

Every fault input first passes through a two-flop synchronizer. A fault must then hold for a set number of cycles before the block acts on it. The block applies the following protections:
- undervoltage blanks all gates and restores them when the supply recovers;
- overtemperature latches off only the switch that overheated;
- overcurrent latches a switch off only when current shutdown is enabled;
- a command that turns on both switches of one leg is refused as shoot-through.

Each leg also waits a programmed dead time before it hands conduction from one side to the other. A status-clear bit in a command word produces a single internal clear pulse and is not stored.

Switch index i runs 0..5. Switch 2b is the low side of leg b and switch 2b+1 is the high side.

Top module: `hb_driver_ctrl`

## Requirements
- R1: After reset all gate enables are 0, the status word is 0 (standby, no flags) and, since all switches are off and detection is enabled, every open-load source enable is 1.
- R2: Command bits [5:0] turn switch i on. With the run bit (bit 14) set, a word loaded with cmd_ld drives gate_en to match those bits by the second clock edge after the load.
- R3: When PWM-select bit 6+i is set, switch i conducts only while pwm_in is high. A switch whose PWM-select bit is clear ignores pwm_in.
- R4: With the run bit at 0 every gate enable is 0, and status bit 15 reads back the run bit.
- R5: A filtered undervoltage forces all gates off and sets status bit 12. When the supply recovers, the gates return to the command, and bit 12 stays set until a clear.
- R6: A filtered overtemperature on switch i turns off only that switch and sets trip bit status[6+i]. The switch stays off after the fault goes away, until a clear.
- R7: A filtered overcurrent sets status bit 13. The switch is also tripped off (status[6+i]) only when command bit 13 is set; otherwise it stays on.
- R8: A word loaded with bit 15 set issues one clear pulse. The pulse zeroes the undervoltage, overload, open-load and trip flags, and the tripped switches return to the command.
- R9: With command bit 12 at 0, the open-load source enable of switch i is 1 exactly while its gate is off. A filtered open-load on a switch whose source is on sets status[i]. With bit 12 at 1, all source enables are 0.
- R10: If both switches of one leg are requested together, both gates of that leg stay off and status bit 13 is set.
- R11: The two gates of a leg are never on together. Between one side turning off and the other turning on there are at least DEAD_CYC cycles with both off.
- R12: A fault input pulse shorter than FILT_CYC cycles has no effect on gates or flags.
- R13: Status bit 14 follows the filtered temperature prewarning and is not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_in | input | 16 | Command word from the serial interface |
| cmd_ld | input | 1 | One-cycle strobe that applies cmd_in |
| pwm_in | input | 1 | External PWM pin (asynchronous) |
| oc_in | input | 6 | Per-switch overcurrent comparators |
| ot_in | input | 6 | Per-switch overtemperature comparators |
| ol_in | input | 6 | Per-switch open-load comparators |
| uv_in | input | 1 | Supply undervoltage comparator |
| tw_in | input | 1 | Temperature prewarning comparator |
| gate_en | output | 6 | Gate enables, switch 2b low side, 2b+1 high side of leg b |
| ol_src_en | output | 6 | Open-load detection current source enables |
| status | output | 16 | {run, prewarn, overload, undervoltage, trip[5:0], open-load[5:0]} |

## Verification
The assertions assume two things about the inputs. First, cmd_ld is a single-cycle strobe. Second, fault and PWM inputs change only between clock edges, so the synchronizers see clean levels. The dead-time check assumes that a leg starts from a settled, off state after reset. The stimulus drives every input on the falling clock edge and pulses cmd_ld for exactly one cycle. It returns each leg to a steady state before it requests the opposite side.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  // Which side of a leg conducted last
  typedef enum logic {SIDE_LO = 1'b0, SIDE_HI = 1'b1} side_e;
endpackage

// File: rtl/hbd_filt.sv
module hbd_filt #(
  parameter int W        = 4,
  parameter int FILT_CYC = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] flt
);
  localparam int FW = $clog2(FILT_CYC + 1);

  logic [W-1:0] s1_q, s2_q, f_q, f_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      f_q  <= '0;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
      f_q  <= f_n;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [FW-1:0] cnt_q, cnt_n;
    always_comb begin
      f_n[i] = s2_q[i] && (f_q[i] || cnt_q == FW'(FILT_CYC - 1));
      cnt_n  = (s2_q[i] && !f_n[i]) ? cnt_q + 1'b1 : '0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_n;
    end
  end

  assign flt = f_q;
endmodule

// File: rtl/hbd_leg.sv
module hbd_leg
  import hbd_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_req,
  input  logic hi_req,
  output logic lo_g,
  output logic hi_g
);
  localparam int CW = $clog2(DEAD_CYC + 2);

  logic          lo_q, hi_q, lo_n, hi_n;
  logic [CW-1:0] cnt_q, cnt_n;
  side_e         last_q, last_n;

  always_comb begin
    lo_n   = lo_req && !hi_q && (cnt_q == '0 || last_q == SIDE_LO);
    hi_n   = hi_req && !lo_q && (cnt_q == '0 || last_q == SIDE_HI);
    cnt_n  = cnt_q;
    last_n = last_q;
    if (lo_q && !lo_n) begin
      cnt_n  = CW'(DEAD_CYC);
      last_n = SIDE_LO;
    end else if (hi_q && !hi_n) begin
      cnt_n  = CW'(DEAD_CYC);
      last_n = SIDE_HI;
    end else if (cnt_q != '0) begin
      cnt_n  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= 1'b0;
      hi_q   <= 1'b0;
      cnt_q  <= '0;
      last_q <= SIDE_LO;
    end else begin
      lo_q   <= lo_n;
      hi_q   <= hi_n;
      cnt_q  <= cnt_n;
      last_q <= last_n;
    end
  end

  assign lo_g = lo_q;
  assign hi_g = hi_q;
endmodule

// File: rtl/hb_driver_ctrl.sv
module hb_driver_ctrl #(
  parameter int N_BR     = 3,
  parameter int DEAD_CYC = 4,
  parameter int FILT_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4*N_BR+3:0] cmd_in,
  input  logic              cmd_ld,
  input  logic              pwm_in,
  input  logic [2*N_BR-1:0] oc_in,
  input  logic [2*N_BR-1:0] ot_in,
  input  logic [2*N_BR-1:0] ol_in,
  input  logic              uv_in,
  input  logic              tw_in,
  output logic [2*N_BR-1:0] gate_en,
  output logic [2*N_BR-1:0] ol_src_en,
  output logic [4*N_BR+3:0] status
);
  localparam int NSW    = 2 * N_BR;
  localparam int B_OLOF = 2 * NSW;
  localparam int B_OCS  = 2 * NSW + 1;
  localparam int B_RUN  = 2 * NSW + 2;
  localparam int B_CLR  = 2 * NSW + 3;
  localparam int FLT_W  = 3 * NSW + 2;

  // Applied command (clear bit is not kept)
  logic [B_RUN:0] cmd_q;
  logic           clr_q;
  logic           pwm_s1_q, pwm_s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      clr_q    <= 1'b0;
      pwm_s1_q <= 1'b0;
      pwm_s2_q <= 1'b0;
    end else begin
      if (cmd_ld) cmd_q <= cmd_in[B_RUN:0];
      clr_q    <= cmd_ld && cmd_in[B_CLR];
      pwm_s1_q <= pwm_in;
      pwm_s2_q <= pwm_s1_q;
    end
  end

  logic [NSW-1:0] on_b, psel_b;
  logic           ol_off, oc_stop, run;
  assign on_b    = cmd_q[NSW-1:0];
  assign psel_b  = cmd_q[2*NSW-1:NSW];
  assign ol_off  = cmd_q[B_OLOF];
  assign oc_stop = cmd_q[B_OCS];
  assign run     = cmd_q[B_RUN];

  // Fault conditioning
  logic [FLT_W-1:0] flt;
  logic [NSW-1:0]   ot_f, oc_f, ol_f;
  logic             uv_f, tw_f;

  hbd_filt #(.W(FLT_W), .FILT_CYC(FILT_CYC)) u_filt (
    .clk (clk),
    .rst_n (rst_n),
    .raw ({tw_in, uv_in, ol_in, oc_in, ot_in}),
    .flt (flt)
  );
  assign {tw_f, uv_f, ol_f, oc_f, ot_f} = flt;

  // Latched flags
  logic [NSW-1:0] trip_q, trip_n, olf_q, olf_n, allow;
  logic           psf_q, psf_n, ovl_q, ovl_n;
  logic [N_BR-1:0] shoot;

  always_comb begin
    allow = on_b & (~psel_b | {NSW{pwm_s2_q}}) & ~trip_q & {NSW{run && !uv_f}};
    for (int b = 0; b < N_BR; b++) shoot[b] = allow[2*b] && allow[2*b+1];
    ol_src_en = ol_off ? '0 : ~gate_en;
    trip_n = clr_q ? '0 : (trip_q | ot_f | (oc_f & {NSW{oc_stop}}));
    olf_n  = clr_q ? '0 : (olf_q | (ol_f & ol_src_en));
    psf_n  = clr_q ? 1'b0 : (psf_q | uv_f);
    ovl_n  = clr_q ? 1'b0 : (ovl_q | (|oc_f) | (|shoot));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q <= '0;
      olf_q  <= '0;
      psf_q  <= 1'b0;
      ovl_q  <= 1'b0;
    end else begin
      trip_q <= trip_n;
      olf_q  <= olf_n;
      psf_q  <= psf_n;
      ovl_q  <= ovl_n;
    end
  end

  // One dead-time sequencer per leg
  for (genvar b = 0; b < N_BR; b++) begin : g_leg
    hbd_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk    (clk),
      .rst_n  (rst_n),
      .lo_req (allow[2*b]   && !shoot[b]),
      .hi_req (allow[2*b+1] && !shoot[b]),
      .lo_g   (gate_en[2*b]),
      .hi_g   (gate_en[2*b+1])
    );
  end

  assign status = {run, tw_f, ovl_q, psf_q, trip_q, olf_q};
endmodule

// File: rtl/hbd_chk.sv
module hbd_chk #(
  parameter int N_BR     = 3,
  parameter int DEAD_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*N_BR-1:0] gate_en,
  input logic [2*N_BR-1:0] trip_st,
  input logic              run_st,
  input logic              psf_st,
  input logic              clr_wr,
  input logic              uv_flt
);
  localparam int CW = $clog2(DEAD_CYC + 1);

  // R4: standby blanks every gate
  a_r4_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run_st |=> gate_en == '0);

  // R5: filtered undervoltage blanks every gate
  a_r5_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flt |=> gate_en == '0);

  // R5: undervoltage flag only drops after a clear write
  a_r5_psf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (psf_st && !clr_wr && !$past(clr_wr)) |=> psf_st);

  for (genvar i = 0; i < 2*N_BR; i++) begin : g_sw
    // R6: a tripped switch is held off
    a_r6_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
      trip_st[i] |=> !gate_en[i]);
  end

  for (genvar b = 0; b < N_BR; b++) begin : g_br
    logic [CW-1:0] off_q;
    logic          last_hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_q     <= CW'(DEAD_CYC);
        last_hi_q <= 1'b0;
      end else begin
        if (gate_en[2*b] || gate_en[2*b+1]) off_q <= '0;
        else if (off_q != CW'(DEAD_CYC))     off_q <= off_q + 1'b1;
        if (gate_en[2*b+1])    last_hi_q <= 1'b1;
        else if (gate_en[2*b]) last_hi_q <= 1'b0;
      end
    end

    // R11: never both sides of a leg
    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_en[2*b] && gate_en[2*b+1]));

    // R11: side change waits for the dead time
    a_r11_dead_lo: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate_en[2*b]) && last_hi_q) |-> off_q >= CW'(DEAD_CYC));
    a_r11_dead_hi: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate_en[2*b+1]) && !last_hi_q) |-> off_q >= CW'(DEAD_CYC));
  end
endmodule

bind hb_driver_ctrl hbd_chk #(.N_BR(N_BR), .DEAD_CYC(DEAD_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .gate_en (gate_en),
  .trip_st (status[4*N_BR-1:2*N_BR]),
  .run_st  (status[4*N_BR+3]),
  .psf_st  (status[4*N_BR]),
  .clr_wr  (cmd_ld && cmd_in[4*N_BR+3]),
  .uv_flt  (uv_f)
);

// File: tb/sim_hb_driver_ctrl.sv
module sim_hb_driver_ctrl;
  localparam int CLK_P = 10;
  localparam int DEAD  = 4;
  localparam int FILT  = 3;
  localparam logic [15:0] RUN = 16'h4000, OCS = 16'h2000, OLOFF = 16'h1000, CLR = 16'h8000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cmd_in = '0;
  logic        cmd_ld = 1'b0, pwm_in = 1'b0, uv_in = 1'b0, tw_in = 1'b0;
  logic [5:0]  oc_in = '0, ot_in = '0, ol_in = '0;
  logic [5:0]  gate_en, ol_src_en;
  logic [15:0] status;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  hb_driver_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .cmd_ld(cmd_ld), .pwm_in(pwm_in),
    .oc_in(oc_in), .ot_in(ot_in), .ol_in(ol_in), .uv_in(uv_in), .tw_in(tw_in),
    .gate_en(gate_en), .ol_src_en(ol_src_en), .status(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] w);
    @(negedge clk);
    cmd_in = w;
    cmd_ld = 1'b1;
    @(negedge clk);
    cmd_ld = 1'b0;
    wait_cyc(12);
  endtask

  task automatic t_reset;
    chk("R1 gates", gate_en, 6'h00);
    chk("R1 status", status, 16'h0000);
    chk("R1 ol sources", ol_src_en, 6'h3F);
  endtask

  task automatic t_direct;
    load(RUN | 16'h0025);
    chk("R2 gates", gate_en, 6'h25);
    chk("R4 run readback", status[15], 1'b1);
    chk("R9 sources on off switches", ol_src_en, 6'h1A);
  endtask

  task automatic t_pwm;
    load(RUN | 16'h0009 | 16'h0040);
    pwm_in = 1'b0; wait_cyc(6);
    chk("R3 pwm low", gate_en, 6'h08);
    pwm_in = 1'b1; wait_cyc(6);
    chk("R3 pwm high", gate_en, 6'h09);
    pwm_in = 1'b0;
    load(RUN | 16'h0009);
    chk("R3 pwm unselected", gate_en, 6'h09);
  endtask

  task automatic t_standby;
    load(16'h0009);
    chk("R4 standby gates", gate_en, 6'h00);
    chk("R4 run readback", status[15], 1'b0);
    load(RUN | 16'h0009);
    chk("R4 resume", gate_en, 6'h09);
  endtask

  task automatic t_uv;
    uv_in = 1'b1; wait_cyc(12);
    chk("R5 uv gates off", gate_en, 6'h00);
    chk("R5 psf set", status[12], 1'b1);
    uv_in = 1'b0; wait_cyc(12);
    chk("R5 recovery gates", gate_en, 6'h09);
    chk("R5 psf held", status[12], 1'b1);
    load(RUN | CLR | 16'h0009);
    chk("R8 psf cleared", status[12], 1'b0);
  endtask

  task automatic t_ot;
    ot_in = 6'h08; wait_cyc(12);
    chk("R6 only hot switch off", gate_en, 6'h01);
    chk("R6 trip bit", status[11:6], 6'h08);
    ot_in = 6'h00; wait_cyc(12);
    chk("R6 stays off", gate_en, 6'h01);
    load(RUN | CLR | 16'h0009);
    chk("R8 trip cleared", status[11:6], 6'h00);
    chk("R8 switch restored", gate_en, 6'h09);
  endtask

  task automatic t_oc;
    oc_in = 6'h01; wait_cyc(12);
    chk("R7 no stop stays on", gate_en, 6'h09);
    chk("R7 ovl set", status[13], 1'b1);
    oc_in = 6'h00;
    load(RUN | OCS | CLR | 16'h0009);
    chk("R8 ovl cleared", status[13], 1'b0);
    oc_in = 6'h01; wait_cyc(12);
    chk("R7 stop trips", gate_en, 6'h08);
    chk("R7 trip bit", status[11:6], 6'h01);
    oc_in = 6'h00;
    load(RUN | CLR | 16'h0009);
    chk("R8 restored after oc", gate_en, 6'h09);
  endtask

  task automatic t_ol;
    chk("R9 sources", ol_src_en, 6'h36);
    ol_in = 6'h02; wait_cyc(12);
    chk("R9 ol flag", status[5:0], 6'h02);
    ol_in = 6'h00;
    load(RUN | CLR | 16'h0009);
    chk("R8 ol cleared", status[5:0], 6'h00);
    load(RUN | OLOFF | 16'h0009);
    chk("R9 sources disabled", ol_src_en, 6'h00);
  endtask

  task automatic t_shoot;
    load(RUN | 16'h0003);
    chk("R10 leg blanked", gate_en, 6'h00);
    chk("R10 ovl set", status[13], 1'b1);
    load(RUN | CLR | 16'h0009);
    chk("R10 clear", status[13], 1'b0);
  endtask

  task automatic t_dead;
    int off_n = 0;
    bit overlap = 0;
    load(RUN | 16'h0002);
    chk("R11 high side on", gate_en[1:0], 2'b10);
    @(negedge clk);
    cmd_in = RUN | 16'h0001; cmd_ld = 1'b1;
    @(negedge clk);
    cmd_ld = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (gate_en[1:0] == 2'b00) off_n++;
      if (gate_en[1:0] == 2'b11) overlap = 1;
      @(negedge clk);
    end
    chk("R11 dead cycles", (off_n >= DEAD), 1);
    chk("R11 no overlap", overlap, 0);
    chk("R11 low side reached", gate_en[1:0], 2'b01);
    load(RUN | 16'h0009);
  endtask

  task automatic t_glitch;
    ot_in = 6'h08; wait_cyc(FILT - 1);
    ot_in = 6'h00; wait_cyc(12);
    chk("R12 glitch gates", gate_en, 6'h09);
    chk("R12 glitch flags", status[13:0], 14'h0000);
  endtask

  task automatic t_tw;
    tw_in = 1'b1; wait_cyc(12);
    chk("R13 prewarn set", status[14], 1'b1);
    tw_in = 1'b0; wait_cyc(12);
    chk("R13 prewarn follows", status[14], 1'b0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_direct();
    t_pwm();
    t_standby();
    t_uv();
    t_ot();
    t_oc();
    t_ol();
    t_shoot();
    t_dead();
    t_glitch();
    t_tw();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule